// File: doc/BRIEF.md
# Quadrature Sine/Cosine Synthesizer with One-Bit Stream Outputs

This block generates a sampled sine and cosine pair from a single phase accumulator. Each assertion of the sample-rate enable advances the phase by a programmable tuning word. The frequency is therefore `tune_word / 2^32` times the enable rate. The upper ten bits of the phase select one of 1024 points on the circle. A 256-entry quarter-wave magnitude table is folded by the two quadrant bits to give both channels. The cosine channel reads the same table at a phase one quarter turn ahead.

Each channel also drives a first-order delta-sigma modulator that runs on every clock. In stream mode, the density of ones on the pin follows the channel's offset-binary sample. A plain RC low-pass can then recover the waveform without a parallel converter. In word mode, the two pins are held low and the modulators stay cleared. The parallel words keep updating in both modes.

Top module: `qdds_quad`

## Requirements
- R1: While `rst_n` is low, `phase_out`, `sin_out`, `cos_out`, `sin_bit` and `cos_bit` are all zero.
- R2: On each clock edge where `sample_en` is high, `phase_out` becomes its old value plus `tune_word`, modulo 2^32. On edges where `sample_en` is low, it keeps its value.
- R3: With k = `phase_out[31:22]`, `sin_out` equals round(2047·sin(2π(k+0.5)/1024)) as a two's complement value. The magnitude is rounded and then the sign is applied.
- R4: `cos_out` uses the same formula as R3, with k replaced by (k+256) mod 1024.
- R5: `sin_out` and `cos_out` are registered. They take the value that R3 and R4 give for the phase present in the cycle before.
- R6: For every sample pair, sin²+cos² lies between 2044² and 2050².
- R7: When `stream_mode` is 1 and the sample is constant, each pin carries the carry of a 12-bit error accumulator that adds the sample's offset-binary code every clock. The offset-binary code is the sample plus 2048. Over any 4096 consecutive clocks, the number of ones is within 1 of that code.
- R8: When `stream_mode` is 0, both `sin_bit` and `cos_bit` are 0 from the next clock edge on.
- R9: A tuning word of 3435974 gives a 400 Hz tone at a 500 kHz enable rate. After 1250 enables from phase 0, `phase_out` equals 204.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Advance the phase by one sample |
| tune_word | input | 32 | Phase increment per sample |
| stream_mode | input | 1 | 1: run the one-bit streams; 0: hold them low |
| phase_out | output | 32 | Phase accumulator value |
| sin_out | output | 12 | Signed sine sample |
| cos_out | output | 12 | Signed cosine sample |
| sin_bit | output | 1 | Delta-sigma stream of the sine sample |
| cos_bit | output | 1 | Delta-sigma stream of the cosine sample |

## Verification
The settling and magnitude properties assume at least two clocks have passed since reset. Before that, the output registers still hold their reset zeros rather than a table value. The stimulus changes `tune_word`, `sample_en` and `stream_mode` only at falling edges, so each rising edge sees one stable value. For the stream average, the sample must stay constant over the whole counting window. The stimulus ensures this by parking the phase with a zero tuning word and letting the pipeline settle before it counts any ones.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

   typedef enum logic {
      OUT_WORD   = 1'b0,
      OUT_STREAM = 1'b1
   } qdds_mode_e;

   // magnitude of a quarter-wave point, sampled at the middle of each bin
   function automatic int quarter_point(input int idx, input int depth, input int peak);
      real ang;
      ang = (real'(idx) + 0.5) * 3.14159265358979323846 / (2.0 * real'(depth));
      return $rtoi($sin(ang) * real'(peak) + 0.5);
   endfunction

endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic [PHASE_W-1:0] step,
   output logic [PHASE_W-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (step_en)
         phase <= phase + step;
   end
endmodule

// File: rtl/qdds_quarter_rom.sv
module qdds_quarter_rom #(
   parameter int ADDR_W = 8,
   parameter int MAG_W  = 11,
   parameter int NPORT  = 2
) (
   input  logic [NPORT*ADDR_W-1:0] addr,
   output logic [NPORT*MAG_W-1:0]  mag
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PEAK  = (1 << MAG_W) - 1;

   logic [MAG_W-1:0] entry [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam int VAL = qdds_pkg::quarter_point(i, DEPTH, PEAK);
      assign entry[i] = MAG_W'(VAL);
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign mag[p*MAG_W +: MAG_W] = entry[addr[p*ADDR_W +: ADDR_W]];
   end
endmodule

// File: rtl/qdds_wave_chan.sv
module qdds_wave_chan #(
   parameter int ADDR_W   = 8,
   parameter int AMP_W    = 12,
   parameter int QUAD_OFS = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W+1:0]       ph_top,
   output logic [ADDR_W-1:0]       rom_addr,
   input  logic [AMP_W-2:0]        rom_mag,
   output logic signed [AMP_W-1:0] sample
);
   logic [1:0]              quad;
   logic [ADDR_W-1:0]       idx;
   logic signed [AMP_W-1:0] mag_ext;
   logic signed [AMP_W-1:0] value;

   always_comb begin
      quad     = ph_top[ADDR_W+1:ADDR_W] + 2'(QUAD_OFS);
      idx      = ph_top[ADDR_W-1:0];
      rom_addr = quad[0] ? ~idx : idx;
      mag_ext  = {1'b0, rom_mag};
      value    = quad[1] ? -mag_ext : mag_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sample <= '0;
      else
         sample <= value;
   end
endmodule

// File: rtl/qdds_dsm1.sv
module qdds_dsm1 #(
   parameter int AMP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [AMP_W-1:0] sample,
   output logic             bit_o
);
   logic [AMP_W-1:0] err;
   logic [AMP_W-1:0] code;
   logic [AMP_W:0]   sum;

   always_comb begin
      code = {~sample[AMP_W-1], sample[AMP_W-2:0]};
      sum  = {1'b0, err} + {1'b0, code};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err   <= '0;
         bit_o <= 1'b0;
      end else if (!run) begin
         err   <= '0;
         bit_o <= 1'b0;
      end else begin
         err   <= sum[AMP_W-1:0];
         bit_o <= sum[AMP_W];
      end
   end
endmodule

// File: rtl/qdds_quad.sv
module qdds_quad #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8,
   parameter int AMP_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_en,
   input  logic [PHASE_W-1:0]      tune_word,
   input  logic                    stream_mode,
   output logic [PHASE_W-1:0]      phase_out,
   output logic signed [AMP_W-1:0] sin_out,
   output logic signed [AMP_W-1:0] cos_out,
   output logic                    sin_bit,
   output logic                    cos_bit
);
   import qdds_pkg::*;

   localparam int NCH   = 2;
   localparam int TOP_W = ADDR_W + 2;
   localparam int MAG_W = AMP_W - 1;

   if (PHASE_W < TOP_W) begin : g_bad_phase
      $error("PHASE_W must cover the table address plus two quadrant bits");
   end
   if (AMP_W < 3) begin : g_bad_amp
      $error("AMP_W must be at least 3");
   end

   logic [TOP_W-1:0]        ph_top;
   logic [NCH*ADDR_W-1:0]   rom_addr;
   logic [NCH*MAG_W-1:0]    rom_mag;
   logic [NCH-1:0][AMP_W-1:0] smp;
   logic [NCH-1:0]          bits;
   qdds_mode_e              mode;

   assign mode = qdds_mode_e'(stream_mode);

   qdds_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .step_en(sample_en),
      .step(tune_word), .phase(phase_out)
   );

   assign ph_top = phase_out[PHASE_W-1 -: TOP_W];

   qdds_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W), .NPORT(NCH)) i_rom (
      .addr(rom_addr), .mag(rom_mag)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [AMP_W-1:0] s;
      qdds_wave_chan #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .QUAD_OFS(c)) i_chan (
         .clk(clk), .rst_n(rst_n), .ph_top(ph_top),
         .rom_addr(rom_addr[c*ADDR_W +: ADDR_W]),
         .rom_mag(rom_mag[c*MAG_W +: MAG_W]),
         .sample(s)
      );
      assign smp[c] = s;
      qdds_dsm1 #(.AMP_W(AMP_W)) i_dsm (
         .clk(clk), .rst_n(rst_n), .run(mode == OUT_STREAM),
         .sample(smp[c]), .bit_o(bits[c])
      );
   end

   assign sin_out = smp[0];
   assign cos_out = smp[1];
   assign sin_bit = bits[0];
   assign cos_bit = bits[1];
endmodule

// File: rtl/qdds_quad_chk.sv
module qdds_quad_chk #(
   parameter int PHASE_W = 32,
   parameter int AMP_W   = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sample_en,
   input logic [PHASE_W-1:0]      tune_word,
   input logic                    stream_mode,
   input logic [PHASE_W-1:0]      phase_out,
   input logic signed [AMP_W-1:0] sin_out,
   input logic signed [AMP_W-1:0] cos_out,
   input logic                    sin_bit,
   input logic                    cos_bit
);
   localparam int PEAK = (1 << (AMP_W - 1)) - 1;

   logic [1:0] age;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end
   assign warm = (age >= 2'd2);

   function automatic int mag_of(input logic signed [AMP_W-1:0] v);
      return (v < 0) ? -int'(v) : int'(v);
   endfunction

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> phase_out == $past(phase_out) + $past(tune_word)); // R2
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(phase_out)); // R2
   AST_SIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mag_of(sin_out) <= PEAK); // R3
   AST_COS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mag_of(cos_out) <= PEAK); // R4
   AST_OUT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(sample_en)) |=> ($stable(sin_out) && $stable(cos_out))); // R5
   AST_PAIR_RADIUS: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (mag_of(sin_out) + mag_of(cos_out) >= PEAK - 4)); // R6
   AST_STREAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !stream_mode |=> (!sin_bit && !cos_bit)); // R8
endmodule

bind qdds_quad qdds_quad_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) i_chk (.*);

// File: tb/test_qdds_quad.sv
module test_qdds_quad;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [31:0] tune_word = '0;
   logic        stream_mode = 1'b0;
   logic [31:0] phase_out;
   logic signed [11:0] sin_out, cos_out;
   logic        sin_bit, cos_bit;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   qdds_quad i_qdds_quad (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tune_word(tune_word),
      .stream_mode(stream_mode), .phase_out(phase_out), .sin_out(sin_out),
      .cos_out(cos_out), .sin_bit(sin_bit), .cos_bit(cos_bit)
   );

   task automatic check(input string req, input longint act, input longint exp, input longint tol);
      n_chk++;
      if (act > exp + tol || act < exp - tol) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model(input logic [31:0] ph, input int ofs);
      int  k;
      real v;
      k = (int'(ph >> 22) + ofs) % 1024;
      v = 2047.0 * $sin(2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / 1024.0);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   task automatic set_phase(input logic [31:0] target);
      @(negedge clk);
      tune_word = target - phase_out;
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
      tune_word = '0;
   endtask

   task automatic t_reset;
      check("R1 phase", phase_out, 0, 0);
      check("R1 sin", sin_out, 0, 0);
      check("R1 cos", cos_out, 0, 0);
      check("R1 bits", {sin_bit, cos_bit}, 0, 0);
   endtask

   task automatic t_step;
      logic [31:0] exp;
      exp = phase_out;
      @(negedge clk);
      tune_word = 32'h1234_5678;
      for (int i = 0; i < 6; i++) begin
         sample_en = (i % 2 == 0);
         if (sample_en) exp = exp + tune_word;
         @(negedge clk);
         check("R2 step/hold", phase_out, exp, 0);
      end
      sample_en = 1'b0;
      set_phase(32'h0);
      tune_word = 32'hF000_0000;
      sample_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      sample_en = 1'b0;
      check("R2 wrap", phase_out, 32'hE000_0000, 0);
      tune_word = '0;
   endtask

   task automatic t_shape;
      logic [31:0] prev;
      int s, c;
      longint r2;
      set_phase(32'h0);
      tune_word = 32'h0040_0000;
      sample_en = 1'b1;
      prev = phase_out;
      for (int i = 0; i < 1030; i++) begin
         @(negedge clk);
         s = sin_out;
         c = cos_out;
         check("R3 R5 sine", s, model(prev, 0), 1);
         check("R4 R5 cosine", c, model(prev, 256), 1);
         r2 = longint'(s) * s + longint'(c) * c;
         check("R6 radius", (r2 >= 2044 * 2044 && r2 <= 2050 * 2050) ? 1 : 0, 1, 0);
         prev = phase_out;
      end
      sample_en = 1'b0;
      tune_word = '0;
   endtask

   task automatic t_stream(input logic [31:0] target);
      int ones_s, ones_c;
      set_phase(target);
      stream_mode = 1'b1;
      repeat (4) @(negedge clk);
      ones_s = 0;
      ones_c = 0;
      for (int i = 0; i < 4096; i++) begin
         @(negedge clk);
         ones_s += sin_bit;
         ones_c += cos_bit;
      end
      check("R7 sine density", ones_s, int'(sin_out) + 2048, 1);
      check("R7 cosine density", ones_c, int'(cos_out) + 2048, 1);
   endtask

   task automatic t_quiet;
      int seen;
      @(negedge clk);
      stream_mode = 1'b0;
      seen = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         seen += sin_bit + cos_bit;
      end
      check("R8 streams held low", seen, 0, 0);
   endtask

   task automatic t_tone;
      set_phase(32'h0);
      tune_word = 32'd3435974;
      sample_en = 1'b1;
      repeat (1250) @(negedge clk);
      sample_en = 1'b0;
      tune_word = '0;
      check("R9 400 Hz period", phase_out, 204, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_step();
      t_shape();
      t_stream(32'h4000_0000);
      t_stream(32'hC000_0000);
      t_stream(32'h2000_0000);
      t_stream(32'h9000_0000);
      t_quiet();
      t_tone();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule